// File: doc/BRIEF.md
# Oversampling Serial Receiver with Character Buffer

This block receives asynchronous serial characters on one input line. A one-cycle enable strobe marks each period of a timebase that runs at sixteen times the bit rate. The block confirms the start bit at its midpoint and samples each later bit sixteen strobes apart, least significant bit first. It then checks the optional parity bit and the stop bit or bits. The finished character goes into a 16-entry buffer with its two error flags. The host sees the oldest entry on a show-ahead read port and removes it with a one-cycle read strobe.

Framing is set by static configuration inputs: 5 to 8 data bits, parity on or off, even or odd parity, and one or two stop bits. The interrupt has two modes. In legacy mode the buffer holds one character and the interrupt means that a character is waiting. A read clears it. In buffered mode the interrupt rises once the number of stored characters reaches a selectable threshold.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `data_ready`, `irq` and `overrun` are low.
- R2: A start bit counts only if the line is still low at the eighth strobe after the falling edge is seen. A low pulse shorter than that stores no character.
- R3: Data bits are taken least significant first. `wlen_sel` 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. Unused upper bits of `rd_data` read as zero.
- R4: When `parity_en` is 1, one parity bit follows the data. `parity_even`=1 expects the data bits plus the parity bit to hold an even number of ones; 0 expects an odd number. On a mismatch, `rd_perr` is 1 for that character. When parity is off, `rd_perr` is 0.
- R5: If any stop bit is sampled low, `rd_ferr` is 1 for that character. With `two_stop`=1 both stop bits are checked.
- R6: Characters come out on `rd_data` in arrival order. A pulse on `rd_en` removes the oldest one. Up to 16 characters are held, and `data_ready` is 1 whenever at least one is held.
- R7: A character that completes while the buffer is at capacity is discarded, and the stored contents stay unchanged. `overrun` goes high and stays high until `ovr_ack` is pulsed.
- R8: In legacy mode (`fifo_mode`=0) the capacity is one character. `irq` is high while a character is held and goes low in the cycle after the read that empties it.
- R9: In buffered mode (`fifo_mode`=1), `irq` is high while the number of held characters is at least the threshold chosen by `trig_sel`: 0, 1, 2, 3 give 1, 4, 8, 14.
- R10: While `irq_en` is 0, `irq` stays low whatever the buffer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable strobe at 16x the bit rate |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| wlen_sel | input | 2 | Data bit count select (5..8) |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 = even parity, 0 = odd |
| two_stop | input | 1 | Check two stop bits |
| fifo_mode | input | 1 | 1 = buffered mode, 0 = legacy single holding |
| trig_sel | input | 2 | Buffered-mode interrupt threshold select |
| irq_en | input | 1 | Interrupt enable |
| rd_en | input | 1 | Read strobe; removes the oldest character |
| ovr_ack | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest held character |
| rd_perr | output | 1 | Parity error of the oldest character |
| rd_ferr | output | 1 | Framing error of the oldest character |
| data_ready | output | 1 | At least one character held |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt |

## Verification
Two synchronizer stages and one output register sit between the middle of the last stop bit and the store, so a character enters the buffer about three clocks plus one strobe period after that midpoint. The bench sends the whole frame, including the second half of the last stop bit, before it samples anything. That leaves more than eight strobes of margin. `irq` and `data_ready` are decoded from the stored count without a register, so after a read strobe they change in the next cycle. The bench checks them two nanoseconds after the following clock edge. Read data is show-ahead, so the bench captures it before it pulses `rd_en`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PARITY, S_STOP
  } rx_state_t;

  // index of the final data bit for a word length select
  function automatic logic [2:0] last_bit_idx(input logic [1:0] sel);
    return 3'(4 + int'(sel));
  endfunction

  // parity bit the sender should have appended
  function automatic logic expected_parity(input logic [7:0] d, input logic even);
    return (^d) ^ ~even;
  endfunction

  // buffered-mode interrupt threshold
  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/rx_deserializer.sv
module rx_deserializer
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_async,
  input  logic [1:0] wlen_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  output logic       char_valid,
  output rx_entry_t  char_out
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);

  logic [1:0]     sync_q;
  logic           rx;
  rx_state_t      state;
  logic [CW-1:0]  cnt;
  logic [2:0]     bit_idx;
  logic [7:0]     shreg;
  logic           par_rx;
  logic           stop_idx;
  logic           ferr_acc;

  // named events for checking
  logic start_check;
  logic bit_sample;

  assign rx          = sync_q[1];
  assign start_check = tick && (state == S_START) && (cnt == MID_CNT);
  assign bit_sample  = tick && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 2'b11;
      state      <= S_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      par_rx     <= 1'b0;
      stop_idx   <= 1'b0;
      ferr_acc   <= 1'b0;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      sync_q     <= {sync_q[0], rx_async};
      char_valid <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!rx) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (cnt == MID_CNT) begin
              cnt <= '0;
              if (!rx) begin
                state   <= S_DATA;
                bit_idx <= '0;
                shreg   <= '0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == LAST_CNT) begin
              cnt            <= '0;
              shreg[bit_idx] <= rx;
              if (bit_idx == last_bit_idx(wlen_sel)) begin
                state    <= par_en ? S_PARITY : S_STOP;
                stop_idx <= 1'b0;
                ferr_acc <= 1'b0;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PARITY: begin
            if (cnt == LAST_CNT) begin
              cnt    <= '0;
              par_rx <= rx;
              state  <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST_CNT) begin
              cnt <= '0;
              if (two_stop && !stop_idx) begin
                stop_idx <= 1'b1;
                ferr_acc <= !rx;
              end else begin
                char_valid    <= 1'b1;
                char_out.data <= shreg;
                char_out.ferr <= ferr_acc | !rx;
                char_out.perr <= par_en & (par_rx != expected_parity(shreg, par_even));
                state         <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R2: a line seen high at the midpoint check abandons the start
  p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_check && rx |=> state == S_IDLE);

  // R3: a character is only delivered out of the stop state
  p_valid_from_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> $past(state) == S_STOP && $past(bit_sample));

endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  rx_entry_t       push_data,
  input  logic            pop,
  output rx_entry_t       head,
  output logic [CNTW-1:0] count
);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [AW-1:0]   LAST_PTR = AW'(DEPTH - 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;

  assign do_push = push && (count != FULL_CNT);
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6: occupancy never exceeds the storage
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R7: a push into a full buffer does not grow it
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push && count == FULL_CNT |=> count <= $past(count));

endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import uart_rx_pkg::*;
#(
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_mode,
  input  logic [1:0]      trig_sel,
  input  logic            irq_en,
  input  logic [CNTW-1:0] count,
  input  logic            char_valid,
  input  logic            accept,
  input  logic            ovr_ack,
  output logic            irq,
  output logic            overrun
);
  logic drop_evt;
  logic level_hit;

  assign drop_evt  = char_valid && !accept;
  assign level_hit = fifo_mode ? (count >= CNTW'(trig_level(trig_sel)))
                               : (count != '0);
  assign irq       = irq_en && level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overrun <= 1'b0;
    else if (drop_evt) overrun <= 1'b1;
    else if (ovr_ack)  overrun <= 1'b0;
  end

  // R7: the overrun flag holds until acknowledged
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_ack |=> overrun);

  // R7: a dropped character always raises the flag
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       serial_in,
  input  logic [1:0] wlen_sel,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       two_stop,
  input  logic       fifo_mode,
  input  logic [1:0] trig_sel,
  input  logic       irq_en,
  input  logic       rd_en,
  input  logic       ovr_ack,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       data_ready,
  output logic       overrun,
  output logic       irq
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic            char_valid;
  rx_entry_t       char_word;
  rx_entry_t       head;
  logic [CNTW-1:0] count;
  logic [CNTW-1:0] capacity;
  logic            accept;
  logic            push;
  logic            pop;

  assign capacity   = fifo_mode ? CNTW'(DEPTH) : CNTW'(1);
  assign accept     = count < capacity;
  assign push       = char_valid && accept;
  assign pop        = rd_en && (count != '0);
  assign data_ready = count != '0;
  assign rd_data    = head.data;
  assign rd_perr    = head.perr;
  assign rd_ferr    = head.ferr;

  rx_deserializer #(.OVS(OVS)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .rx_async   (serial_in),
    .wlen_sel   (wlen_sel),
    .par_en     (parity_en),
    .par_even   (parity_even),
    .two_stop   (two_stop),
    .char_valid (char_valid),
    .char_out   (char_word)
  );

  rx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (char_word),
    .pop       (pop),
    .head      (head),
    .count     (count)
  );

  rx_irq_ctrl #(.CNTW(CNTW)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode  (fifo_mode),
    .trig_sel   (trig_sel),
    .irq_en     (irq_en),
    .count      (count),
    .char_valid (char_valid),
    .accept     (accept),
    .ovr_ack    (ovr_ack),
    .irq        (irq),
    .overrun    (overrun)
  );

  // R8: in legacy mode, reading the only held character drops the interrupt
  p_legacy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && rd_en && count == CNTW'(1) && !push |=> !irq);

  // R8: legacy mode never holds more than one character when entered empty
  p_legacy_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode && count == '0 |=> count <= CNTW'(1));

endmodule

// File: tb/sim_uart_rx_fifo.sv
module sim_uart_rx_fifo;
  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       serial_in = 1'b1;
  logic [1:0] wlen_sel = 2'd3;
  logic       parity_en = 1'b0;
  logic       parity_even = 1'b1;
  logic       two_stop = 1'b0;
  logic       fifo_mode = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic       irq_en = 1'b1;
  logic       rd_en = 1'b0;
  logic       ovr_ack = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, data_ready, overrun, irq;

  int n_checks = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) tick16 <= ~tick16;

  uart_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .serial_in(serial_in),
    .wlen_sel(wlen_sel), .parity_en(parity_en), .parity_even(parity_even),
    .two_stop(two_stop), .fifo_mode(fifo_mode), .trig_sel(trig_sel),
    .irq_en(irq_en), .rd_en(rd_en), .ovr_ack(ovr_ack), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .data_ready(data_ready),
    .overrun(overrun), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic hold_bit(input logic v);
    serial_in = v;
    repeat (BITCLK) @(posedge clk);
  endtask

  // build a frame: start, data LSB first, optional parity, stop bits
  task automatic send(input logic [7:0] d, input int nb, input bit flip_par,
                      input bit stop1_low, input bit stop2_low);
    int ones;
    logic pbit;
    @(posedge clk); #1;
    hold_bit(1'b0);
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      hold_bit(d[i]);
      if (d[i]) ones++;
    end
    if (parity_en) begin
      pbit = parity_even ? logic'(ones % 2) : logic'((ones + 1) % 2);
      hold_bit(pbit ^ flip_par);
    end
    hold_bit(!stop1_low);
    if (two_stop) hold_bit(!stop2_low);
    hold_bit(1'b1);
    @(posedge clk); #2;
  endtask

  task automatic send8(input logic [7:0] d);
    send(d, 8, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic pop_one();
    @(posedge clk); #1;
    rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(posedge clk); #2;
  endtask

  task automatic ack_ovr();
    @(posedge clk); #1;
    ovr_ack = 1'b1;
    @(posedge clk); #1;
    ovr_ack = 1'b0;
    @(posedge clk); #2;
  endtask

  task automatic drain();
    while (data_ready) pop_one();
  endtask

  task automatic t_reset();
    check("R1 data_ready", {7'd0, data_ready}, 8'd0);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 overrun", {7'd0, overrun}, 8'd0);
  endtask

  task automatic t_basic();
    send8(8'hA5);
    check("R3 ready", {7'd0, data_ready}, 8'd1);
    check("R3 data", rd_data, 8'hA5);
    check("R5 no ferr", {7'd0, rd_ferr}, 8'd0);
    check("R4 no perr", {7'd0, rd_perr}, 8'd0);
    pop_one();
    check("R6 empty after read", {7'd0, data_ready}, 8'd0);
  endtask

  task automatic t_wordlen();
    logic [7:0] pat;
    for (int s = 0; s < 3; s++) begin
      wlen_sel = 2'(s);
      pat = 8'hFF >> (3 - s);
      send(8'hFF, 5 + s, 1'b0, 1'b0, 1'b0);
      check("R3 word length", rd_data, pat);
      pop_one();
    end
    wlen_sel = 2'd3;
    send8(8'h01);
    check("R3 lsb first", rd_data, 8'h01);
    pop_one();
  endtask

  task automatic t_parity();
    parity_en = 1'b1;
    parity_even = 1'b1;
    send(8'h37, 8, 1'b0, 1'b0, 1'b0);
    check("R4 even good", {7'd0, rd_perr}, 8'd0);
    check("R4 data", rd_data, 8'h37);
    pop_one();
    send(8'h37, 8, 1'b1, 1'b0, 1'b0);
    check("R4 even bad", {7'd0, rd_perr}, 8'd1);
    pop_one();
    parity_even = 1'b0;
    send(8'hC1, 8, 1'b0, 1'b0, 1'b0);
    check("R4 odd good", {7'd0, rd_perr}, 8'd0);
    pop_one();
    send(8'hC1, 8, 1'b1, 1'b0, 1'b0);
    check("R4 odd bad", {7'd0, rd_perr}, 8'd1);
    pop_one();
    parity_en = 1'b0;
    parity_even = 1'b1;
  endtask

  task automatic t_framing();
    send(8'h5A, 8, 1'b0, 1'b1, 1'b0);
    check("R5 stop low", {7'd0, rd_ferr}, 8'd1);
    pop_one();
    two_stop = 1'b1;
    send(8'h5A, 8, 1'b0, 1'b0, 1'b1);
    check("R5 second stop low", {7'd0, rd_ferr}, 8'd1);
    pop_one();
    send(8'h5A, 8, 1'b0, 1'b0, 1'b0);
    check("R5 two stops good", {7'd0, rd_ferr}, 8'd0);
    check("R5 data", rd_data, 8'h5A);
    pop_one();
    two_stop = 1'b0;
  endtask

  task automatic t_false_start();
    @(posedge clk); #1;
    serial_in = 1'b0;
    repeat (8) @(posedge clk);
    serial_in = 1'b1;
    repeat (20 * BITCLK) @(posedge clk);
    #2;
    check("R2 glitch ignored", {7'd0, data_ready}, 8'd0);
  endtask

  task automatic t_order_overrun();
    for (int i = 0; i < 16; i++) send8(8'(8'h30 + i));
    check("R6 ready when full", {7'd0, data_ready}, 8'd1);
    check("R7 no overrun yet", {7'd0, overrun}, 8'd0);
    send8(8'hEE);
    check("R7 overrun set", {7'd0, overrun}, 8'd1);
    for (int i = 0; i < 16; i++) begin
      check("R6 order", rd_data, 8'(8'h30 + i));
      pop_one();
    end
    check("R7 extra dropped", {7'd0, data_ready}, 8'd0);
    check("R7 sticky", {7'd0, overrun}, 8'd1);
    ack_ovr();
    check("R7 cleared", {7'd0, overrun}, 8'd0);
  endtask

  task automatic t_legacy();
    fifo_mode = 1'b0;
    irq_en = 1'b1;
    @(posedge clk); #2;
    check("R8 idle irq", {7'd0, irq}, 8'd0);
    send8(8'h11);
    check("R8 irq on char", {7'd0, irq}, 8'd1);
    send8(8'h22);
    check("R8 cap one overrun", {7'd0, overrun}, 8'd1);
    check("R8 first kept", rd_data, 8'h11);
    pop_one();
    check("R8 irq cleared by read", {7'd0, irq}, 8'd0);
    check("R8 second dropped", {7'd0, data_ready}, 8'd0);
    ack_ovr();
    fifo_mode = 1'b1;
  endtask

  task automatic t_trigger();
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) send8(8'(i));
    check("R9 below 4", {7'd0, irq}, 8'd0);
    send8(8'h03);
    check("R9 at 4", {7'd0, irq}, 8'd1);
    pop_one();
    check("R9 back to 3", {7'd0, irq}, 8'd0);
    drain();
    trig_sel = 2'd0;
    send8(8'h44);
    check("R9 level 1", {7'd0, irq}, 8'd1);
    irq_en = 1'b0;
    @(posedge clk); #2;
    check("R10 disabled", {7'd0, irq}, 8'd0);
    irq_en = 1'b1;
    drain();
    trig_sel = 2'd2;
    for (int i = 0; i < 7; i++) send8(8'(i));
    check("R9 below 8", {7'd0, irq}, 8'd0);
    send8(8'h07);
    check("R9 at 8", {7'd0, irq}, 8'd1);
    trig_sel = 2'd3;
    for (int i = 0; i < 5; i++) send8(8'(i));
    check("R9 below 14", {7'd0, irq}, 8'd0);
    send8(8'h0D);
    check("R9 at 14", {7'd0, irq}, 8'd1);
    drain();
    trig_sel = 2'd0;
  endtask

  initial begin
    #3;
    t_reset();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_basic();
    t_wordlen();
    t_parity();
    t_framing();
    t_false_start();
    t_order_overrun();
    t_legacy();
    t_trigger();
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule